// File: doc/BRIEF.md
# Same-Line Load Ordering Guard

This block tracks the loads in flight in a small load queue of an out-of-order core. Its job is to keep two loads that touch the same cache line in program order, even when a coherence invalidation races with a load's data return. Entries are taken from the tail in program order. Each entry records four events:

- its line address resolving,
- its data coming back,
- an external invalidation snooping it,
- a data return that carries an invalidate along with it.

When a younger load has already returned data and an older load then resolves to the same line, the younger load does not have to be discarded at once. It is only marked as a possible violation. A later invalidation of that line turns the mark into a re-execute fault. A younger load that has already seen an invalidation gets the fault directly.

A data return that carries an invalidate is treated in two steps. It first completes its own load. It is then applied as an invalidation of its line against every entry. The load that received it is marked as externally snooped. A pending fault is never lost: a data return for a faulted entry suppresses the register write and keeps the fault.

At commit, the oldest entry either retires or, if it holds a fault, raises a squash request. On a squash, that entry and every younger entry are flushed and the tail moves back to the faulting slot. The pipeline squash itself is outside the block.

Top module: `lsq_order_guard`

## Requirements
- R1: After reset the queue is empty (`empty_o`=1), `alloc_ready_o`=1, `alloc_idx_o`=0 and `head_idx_o`=0.
- R2: Allocation takes slots in increasing index order starting at the tail, wrapping modulo DEPTH. When DEPTH entries are held, `alloc_ready_o` is 0 and an allocation request is ignored.
- R3: If an older entry resolves to the line of a younger entry that has returned data and has not been snooped, the younger entry is only marked as a possible violation. With no later invalidation it retires normally.
- R4: If an older entry resolves to the line of a younger entry that has returned data and was hit by an external invalidation, the younger entry takes a re-execute fault.
- R5: An external invalidation whose line equals that of an entry marked as a possible violation gives that entry a re-execute fault.
- R6: A data return with `resp_inv_i`=1 completes its own entry and also acts as an invalidation of that entry's line against all entries.
- R7: A data return with `resp_inv_i`=1 marks its own entry as snooped. An older entry that resolves to the same line later makes that entry fault.
- R8: A data return to an entry that already holds a fault gives `wb_suppr_o`=1 and `wb_valid_o`=0. The fault is kept. A data return to a live entry without a fault gives `wb_valid_o`=1 in the same cycle.
- R9: When a data return and an external invalidation arrive in the same cycle, the data return is applied first. The invalidation therefore sees the entry as completed and marks it as snooped.
- R10: With `commit_i`=1, a non-empty queue and a completed, fault-free head, `retire_o` pulses and `head_idx_o` advances by one on the next cycle. A head whose data has not returned produces neither retire nor squash.
- R11: With `commit_i`=1 and a completed head holding a fault, `squash_o`=1 and `squash_idx_o` equals the head index in that cycle. On the next cycle the queue is empty and `alloc_idx_o` equals that index.
- R12: Lines compare on address bits [ADDR_W-1:LINE_OFF] only. Addresses that differ only below bit LINE_OFF (default 6) match; addresses that differ above it do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_i | input | 1 | Request a new entry at the tail |
| alloc_ready_o | output | 1 | An allocation this cycle is accepted |
| alloc_idx_o | output | IDX_W | Slot the next allocation takes |
| resolve_i | input | 1 | An entry's address resolves |
| resolve_idx_i | input | IDX_W | Entry whose address resolves |
| resolve_addr_i | input | ADDR_W | Resolved byte address |
| resp_i | input | 1 | Data returns for an entry |
| resp_idx_i | input | IDX_W | Entry receiving data |
| resp_inv_i | input | 1 | The data return also carries an invalidate |
| snoop_i | input | 1 | External invalidation |
| snoop_addr_i | input | ADDR_W | Invalidated byte address |
| commit_i | input | 1 | Try to commit the oldest entry |
| wb_valid_o | output | 1 | The returned data is written to the destination |
| wb_suppr_o | output | 1 | The returned data is dropped because of a pending fault |
| retire_o | output | 1 | Oldest entry retires this cycle |
| squash_o | output | 1 | Squash request for the oldest entry |
| squash_idx_o | output | IDX_W | Entry to re-execute |
| head_idx_o | output | IDX_W | Index of the oldest entry |
| empty_o | output | 1 | No entries held |

## Verification
The bench targets the race orderings:

- **Invalidate before older resolve.** An invalidation reaches a younger load before the older load resolves. A design that treats this like the unsnooped case would only mark the load and then let it retire with stale data.
- **Combined invalidate.** A data return carries an invalidate. A design that drops that part lets a marked sibling retire instead of squashing it.
- **Same-cycle return and invalidation.** Both arrive in one cycle. Evaluating the invalidation first would leave the entry unsnooped and miss the later fault.
- **Return to a faulted entry.** A design that writes back and clears the fault would retire the entry instead of squashing it.

The bench also checks line matching at both sides of the offset boundary, and the tail rewind after a squash.

// File: rtl/lsq_ord_pkg.sv
package lsq_ord_pkg;

  // Per-entry status bits.
  typedef struct packed {
    logic valid;   // slot holds a load
    logic addr_ok; // line address known
    logic done;    // data has returned
    logic pviol;   // possible ordering violation
    logic ext;     // hit by an invalidation after completion
    logic fault;   // re-execute pending
  } ent_flags_t;

  typedef enum logic [1:0] {
    CMT_IDLE   = 2'd0,
    CMT_RETIRE = 2'd1,
    CMT_SQUASH = 2'd2
  } cmt_t;

endpackage

// File: rtl/lsq_ord_ptrs.sv
module lsq_ord_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_go,
  input  logic             retire_go,
  input  logic             squash_go,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic             full,
  output logic             empty
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [IDX_W-1:0] head_q, head_n, tail_q, tail_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             upd;

  always_comb begin
    head_n = head_q;
    tail_n = tail_q;
    cnt_n  = cnt_q;
    if (squash_go) begin
      // faulting head and everything younger goes; tail rewinds to it
      tail_n = head_q;
      cnt_n  = '0;
    end else begin
      if (alloc_go)  tail_n = tail_q + IDX_W'(1);
      if (retire_go) head_n = head_q + IDX_W'(1);
      cnt_n = cnt_q + CNT_W'(alloc_go) - CNT_W'(retire_go);
    end
  end

  assign upd = alloc_go | retire_go | squash_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      head_q <= head_n;
      tail_q <= tail_n;
      cnt_q  <= cnt_n;
    end
  end

  assign head  = head_q;
  assign tail  = tail_q;
  assign full  = (cnt_q == CNT_FULL);
  assign empty = (cnt_q == '0);

endmodule

// File: rtl/lsq_ord_cmp.sv
module lsq_ord_cmp #(
  parameter int DEPTH  = 8,
  parameter int LINE_W = 26
) (
  input  logic [LINE_W-1:0] lines [DEPTH],
  input  logic [LINE_W-1:0] probe,
  output logic [DEPTH-1:0]  hit
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit[g] = (lines[g] == probe);
  end

endmodule

// File: rtl/lsq_ord_younger.sv
module lsq_ord_younger #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0] head,
  input  logic [IDX_W-1:0] ref_idx,
  output logic [DEPTH-1:0] younger
);

  // Age is distance from the head; DEPTH must be a power of two.
  logic [IDX_W-1:0] ref_age;
  assign ref_age = ref_idx - head;

  for (genvar g = 0; g < DEPTH; g++) begin : g_age
    logic [IDX_W-1:0] ent_age;
    assign ent_age    = IDX_W'(g) - head;
    assign younger[g] = (ent_age > ref_age);
  end

endmodule

// File: rtl/lsq_order_guard.sv
module lsq_order_guard #(
  parameter int DEPTH    = 8,
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 6,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int LINE_W  = ADDR_W - LINE_OFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  output logic              alloc_ready_o,
  output logic [IDX_W-1:0]  alloc_idx_o,
  input  logic              resolve_i,
  input  logic [IDX_W-1:0]  resolve_idx_i,
  input  logic [ADDR_W-1:0] resolve_addr_i,
  input  logic              resp_i,
  input  logic [IDX_W-1:0]  resp_idx_i,
  input  logic              resp_inv_i,
  input  logic              snoop_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  input  logic              commit_i,
  output logic              wb_valid_o,
  output logic              wb_suppr_o,
  output logic              retire_o,
  output logic              squash_o,
  output logic [IDX_W-1:0]  squash_idx_o,
  output logic [IDX_W-1:0]  head_idx_o,
  output logic              empty_o
);

  import lsq_ord_pkg::*;

  ent_flags_t        flg_q [DEPTH];
  ent_flags_t        flg_n [DEPTH];
  logic [LINE_W-1:0] line_q [DEPTH];

  logic [IDX_W-1:0]  head, tail;
  logic              full, empty;
  logic              alloc_go;
  cmt_t              cmt;

  logic [LINE_W-1:0] res_line, snp_line, inv_line;
  logic [DEPTH-1:0]  hit_res, hit_snp, hit_inv, young_res;
  logic              res_ok, resp_ok, inv_ok;

  assign res_line = resolve_addr_i[ADDR_W-1:LINE_OFF];
  assign snp_line = snoop_addr_i[ADDR_W-1:LINE_OFF];
  assign inv_line = line_q[resp_idx_i];

  lsq_ord_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_go  (alloc_go),
    .retire_go (cmt == CMT_RETIRE),
    .squash_go (cmt == CMT_SQUASH),
    .head      (head),
    .tail      (tail),
    .full      (full),
    .empty     (empty)
  );

  lsq_ord_cmp #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_cmp_res (
    .lines (line_q), .probe (res_line), .hit (hit_res)
  );

  lsq_ord_cmp #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_cmp_snp (
    .lines (line_q), .probe (snp_line), .hit (hit_snp)
  );

  lsq_ord_cmp #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_cmp_inv (
    .lines (line_q), .probe (inv_line), .hit (hit_inv)
  );

  lsq_ord_younger #(.DEPTH(DEPTH)) u_young (
    .head    (head),
    .ref_idx (resolve_idx_i),
    .younger (young_res)
  );

  // Commit decision on the registered head entry.
  always_comb begin
    cmt = CMT_IDLE;
    if (commit_i && !empty && flg_q[head].valid && flg_q[head].done)
      cmt = flg_q[head].fault ? CMT_SQUASH : CMT_RETIRE;
  end

  assign alloc_ready_o = !full && (cmt != CMT_SQUASH);
  assign alloc_go      = alloc_i && alloc_ready_o;

  assign res_ok  = resolve_i && flg_q[resolve_idx_i].valid;
  assign resp_ok = resp_i && flg_q[resp_idx_i].valid;
  assign inv_ok  = resp_ok && resp_inv_i && flg_q[resp_idx_i].addr_ok;

  // A pending fault blocks the writeback and survives it.
  assign wb_valid_o = resp_ok && !flg_q[resp_idx_i].fault;
  assign wb_suppr_o = resp_ok &&  flg_q[resp_idx_i].fault;

  // Next state: resolve, then data return, then the invalidate carried
  // by that return, then the external invalidation, then commit/alloc.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) flg_n[i] = flg_q[i];

    if (res_ok) begin
      flg_n[resolve_idx_i].addr_ok = 1'b1;
      for (int j = 0; j < DEPTH; j++) begin
        if (young_res[j] && hit_res[j] && flg_q[j].valid &&
            flg_q[j].addr_ok && flg_q[j].done) begin
          if (flg_q[j].ext) flg_n[j].fault = 1'b1;
          else              flg_n[j].pviol = 1'b1;
        end
      end
    end

    if (resp_ok) begin
      flg_n[resp_idx_i].done = 1'b1;
      if (resp_inv_i) flg_n[resp_idx_i].ext = 1'b1;
    end

    if (inv_ok) begin
      for (int j = 0; j < DEPTH; j++) begin
        if (hit_inv[j] && flg_q[j].valid && flg_q[j].addr_ok) begin
          if (flg_n[j].done)  flg_n[j].ext   = 1'b1;
          if (flg_n[j].pviol) flg_n[j].fault = 1'b1;
        end
      end
    end

    if (snoop_i) begin
      for (int j = 0; j < DEPTH; j++) begin
        if (hit_snp[j] && flg_q[j].valid && flg_q[j].addr_ok) begin
          if (flg_n[j].done)  flg_n[j].ext   = 1'b1;
          if (flg_n[j].pviol) flg_n[j].fault = 1'b1;
        end
      end
    end

    if (cmt == CMT_RETIRE) flg_n[head] = '0;
    if (cmt == CMT_SQUASH) begin
      for (int i = 0; i < DEPTH; i++) flg_n[i] = '0;
    end

    if (alloc_go) begin
      flg_n[tail]       = '0;
      flg_n[tail].valid = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) flg_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) flg_q[i] <= flg_n[i];
    end
  end

  // Line tags: datapath only, loaded when the address resolves.
  for (genvar g = 0; g < DEPTH; g++) begin : g_line
    logic line_en;
    assign line_en = res_ok && (resolve_idx_i == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (line_en) line_q[g] <= res_line;
    end
  end

  assign alloc_idx_o  = tail;
  assign retire_o     = (cmt == CMT_RETIRE);
  assign squash_o     = (cmt == CMT_SQUASH);
  assign squash_idx_o = head;
  assign head_idx_o   = head;
  assign empty_o      = empty;

endmodule

// File: rtl/lsq_order_guard_chk.sv
module lsq_order_guard_chk #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_ready_o,
  input logic [IDX_W-1:0] alloc_idx_o,
  input logic             wb_valid_o,
  input logic             wb_suppr_o,
  input logic             retire_o,
  input logic             squash_o,
  input logic [IDX_W-1:0] squash_idx_o,
  input logic [IDX_W-1:0] head_idx_o,
  input logic             empty_o
);

  a_r11_squash_empties: assert property (@(posedge clk) disable iff (!rst_n)
    squash_o |=> empty_o);

  a_r11_tail_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    squash_o |=> (alloc_idx_o == $past(squash_idx_o)));

  a_r10_head_steps: assert property (@(posedge clk) disable iff (!rst_n)
    retire_o |=> (head_idx_o == IDX_W'($past(head_idx_o) + 1'b1)));

  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(retire_o && squash_o));

  a_r8_wb_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_valid_o && wb_suppr_o));

  a_r2_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && !squash_o) |-> alloc_ready_o);

  a_r10_no_commit_empty: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> !(retire_o || squash_o));

endmodule

bind lsq_order_guard lsq_order_guard_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .alloc_ready_o (alloc_ready_o),
  .alloc_idx_o   (alloc_idx_o),
  .wb_valid_o    (wb_valid_o),
  .wb_suppr_o    (wb_suppr_o),
  .retire_o      (retire_o),
  .squash_o      (squash_o),
  .squash_idx_o  (squash_idx_o),
  .head_idx_o    (head_idx_o),
  .empty_o       (empty_o)
);

// File: tb/lsq_order_guard_tb.sv
`timescale 1ns/1ps
module lsq_order_guard_tb;

  localparam int DEPTH  = 8;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 3;
  localparam logic [ADDR_W-1:0] LA = 32'h0000_1040; // line A
  localparam logic [ADDR_W-1:0] LB = 32'h0000_2040; // other line

  logic clk, rst_n;
  logic alloc_i, alloc_ready_o;
  logic [IDX_W-1:0] alloc_idx_o;
  logic resolve_i; logic [IDX_W-1:0] resolve_idx_i; logic [ADDR_W-1:0] resolve_addr_i;
  logic resp_i; logic [IDX_W-1:0] resp_idx_i; logic resp_inv_i;
  logic snoop_i; logic [ADDR_W-1:0] snoop_addr_i;
  logic commit_i;
  logic wb_valid_o, wb_suppr_o, retire_o, squash_o, empty_o;
  logic [IDX_W-1:0] squash_idx_o, head_idx_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  // values captured just before the clock edge of an operation
  logic c_wb, c_sup, c_ret, c_sq, c_ar;
  logic [IDX_W-1:0] c_sqi, c_ai;

  lsq_order_guard #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_OFF(6)) u_dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    alloc_i = 0; resolve_i = 0; resolve_idx_i = '0; resolve_addr_i = '0;
    resp_i = 0; resp_idx_i = '0; resp_inv_i = 0;
    snoop_i = 0; snoop_addr_i = '0; commit_i = 0;
  endtask

  task automatic tick();
    #1;
    c_wb = wb_valid_o; c_sup = wb_suppr_o; c_ret = retire_o; c_sq = squash_o;
    c_sqi = squash_idx_o; c_ar = alloc_ready_o; c_ai = alloc_idx_o;
    @(posedge clk); #0.5;
    clr();
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; clr();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic op_alloc();
    @(negedge clk); alloc_i = 1; tick();
  endtask
  task automatic op_resolve(int idx, logic [ADDR_W-1:0] a);
    @(negedge clk); resolve_i = 1; resolve_idx_i = IDX_W'(idx); resolve_addr_i = a; tick();
  endtask
  task automatic op_resp(int idx, bit inv);
    @(negedge clk); resp_i = 1; resp_idx_i = IDX_W'(idx); resp_inv_i = inv; tick();
  endtask
  task automatic op_snoop(logic [ADDR_W-1:0] a);
    @(negedge clk); snoop_i = 1; snoop_addr_i = a; tick();
  endtask
  task automatic op_commit();
    @(negedge clk); commit_i = 1; tick();
  endtask

  // R1
  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1 empty", empty_o, 1);
    chk("R1 alloc_ready", alloc_ready_o, 1);
    chk("R1 alloc_idx", alloc_idx_o, 0);
    chk("R1 head", head_idx_o, 0);
  endtask

  // R2: fill in order, then refuse
  task automatic t_fill();
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      op_alloc();
      chk("R2 alloc slot", c_ai, i);
    end
    op_alloc();
    chk("R2 ready low when full", c_ar, 0);
    @(negedge clk);
    chk("R2 tail held when full", alloc_idx_o, 0);
  endtask

  // R3, R10: mark only, retire normally
  task automatic t_mark_only();
    do_reset();
    op_alloc(); op_alloc();
    op_resolve(1, LA);
    op_resp(1, 0);
    chk("R8 wb on clean return", c_wb, 1);
    op_resolve(0, LA + 4);
    op_resp(0, 0);
    op_commit();
    chk("R10 retire older", c_ret, 1);
    @(negedge clk);
    chk("R10 head advanced", head_idx_o, 1);
    op_commit();
    chk("R3 younger retires without squash", c_ret, 1);
    chk("R3 no squash", c_sq, 0);
  endtask

  // R5, R11, R12
  task automatic t_snoop_fault();
    do_reset();
    op_alloc(); op_alloc();
    op_resolve(1, LA);
    op_resp(1, 0);
    op_resolve(0, LA);
    op_resp(0, 0);
    op_snoop(LB);
    op_commit();
    chk("R12 other line no effect on older", c_ret, 1);
    op_snoop(LA + 8);
    op_commit();
    chk("R5 squash on snooped marked load", c_sq, 1);
    chk("R11 squash index", c_sqi, 1);
    @(negedge clk);
    chk("R11 queue empty after squash", empty_o, 1);
    chk("R11 tail rewound", alloc_idx_o, 1);
  endtask

  // R12: different line leaves marked load alone
  task automatic t_line_miss();
    do_reset();
    op_alloc(); op_alloc();
    op_resolve(1, LA);
    op_resp(1, 0);
    op_resolve(0, LA + 63);
    op_resp(0, 0);
    op_snoop(LA + 64);
    op_commit(); op_commit();
    chk("R12 next line leaves marked load", c_ret, 1);
  endtask

  // R4: snooped before the older resolves
  task automatic t_ext_then_resolve();
    do_reset();
    op_alloc(); op_alloc();
    op_resolve(1, LA);
    op_resp(1, 0);
    op_snoop(LA);
    op_resolve(0, LA);
    op_resp(0, 0);
    op_commit(); op_commit();
    chk("R4 squash of snooped younger", c_sq, 1);
    chk("R4 squash index", c_sqi, 1);
  endtask

  // R7: combined return marks own entry
  task automatic t_comb_self();
    do_reset();
    op_alloc(); op_alloc();
    op_resolve(1, LA);
    op_resp(1, 1);
    chk("R7 combined return writes back", c_wb, 1);
    op_resolve(0, LA);
    op_resp(0, 0);
    op_commit();
    chk("R7 older retires", c_ret, 1);
    op_commit();
    chk("R7 receiving load squashed", c_sq, 1);
  endtask

  // R6, R8: combined return faults a sibling; fault survives a return
  task automatic t_comb_sibling();
    do_reset();
    op_alloc(); op_alloc(); op_alloc();
    op_resolve(1, LA);
    op_resp(1, 0);
    op_resolve(0, LA);
    op_resolve(2, LA + 16);
    op_resp(2, 1);
    op_resp(1, 0);
    chk("R8 suppressed on faulted entry", c_sup, 1);
    chk("R8 no writeback on faulted entry", c_wb, 0);
    op_resp(0, 0);
    op_commit();
    chk("R6 older retires", c_ret, 1);
    op_commit();
    chk("R6 sibling squashed", c_sq, 1);
    chk("R8 fault kept, squash index", c_sqi, 1);
  endtask

  // R9: same-cycle return and invalidation
  task automatic t_same_cycle();
    do_reset();
    op_alloc(); op_alloc();
    op_resolve(1, LA);
    @(negedge clk);
    resp_i = 1; resp_idx_i = 1; snoop_i = 1; snoop_addr_i = LA;
    tick();
    chk("R9 writeback still happens", c_wb, 1);
    op_resolve(0, LA);
    op_resp(0, 0);
    op_commit(); op_commit();
    chk("R9 return applied before snoop", c_sq, 1);
  endtask

  // R10: head not complete
  task automatic t_stall();
    do_reset();
    op_alloc();
    op_commit();
    chk("R10 no retire without data", c_ret, 0);
    chk("R10 no squash without data", c_sq, 0);
    op_resolve(0, LB);
    op_resp(0, 0);
    op_commit();
    chk("R10 retire after data", c_ret, 1);
    @(negedge clk);
    chk("R10 empty after retire", empty_o, 1);
  endtask

  initial begin
    rst_n = 0; clr();
    t_reset();
    t_fill();
    t_mark_only();
    t_snoop_fault();
    t_line_miss();
    t_ext_then_resolve();
    t_comb_self();
    t_comb_sibling();
    t_same_cycle();
    t_stall();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule